// File: doc/BRIEF.md
# Single-Operand ALU with Status Flags

This block executes the one-operand arithmetic and logic group of an 8-bit processor: bitwise complement, two's-complement negate, increment, decrement, and three right shifts (arithmetic, logical, and rotate through carry). Each cycle it accepts a 16-bit instruction word, the current value of the destination operand and the current status byte. One clock later it returns the computed result, the 5-bit destination register index taken from the instruction, and the updated status byte.

Every operation has its own rule for the status flags. Flags that an operation does not touch pass through from the incoming status byte unchanged. An instruction word outside this group is still accepted. The block then flags it as not recognised and hands the operand and the status byte back untouched, so the surrounding pipeline can route it elsewhere.

The status byte uses the following fixed layout: bit 0 carry (C), bit 1 zero (Z), bit 2 negative (N), bit 3 overflow (V), bit 4 sign (S), bit 5 half carry (H). Bits 7:6 belong to other logic.

Top module: `unary_alu`

## Requirements
- R1: An instruction is recognised when bits 15:9 equal 1001010 and bits 3:0 hold one of 0000, 0001, 0011, 0101, 0110, 0111, 1010. `dest` is instruction bits 8:4. The outputs register one cycle after `in_valid`, `out_valid` follows `in_valid` with one cycle of delay, and reset clears every output to zero.
- R2: Nibble 0000 (complement): the result is the bitwise inverse of the operand, C is set to 1, V is cleared, and N is result bit 7.
- R3: Nibble 0001 (negate): the result is 0 minus the operand. V is set only for a result of 0x80, C is set for any nonzero result, N is result bit 7, and H is bit 3 of (result AND NOT operand).
- R4: Nibble 0011 (increment): the result is the operand plus 1, modulo 256. V is set only when the result is 0x80, N is result bit 7, and C is left unchanged.
- R5: Nibble 1010 (decrement): the result is the operand minus 1, modulo 256. V is set only when the result is 0x7F, N is result bit 7, and C is left unchanged.
- R6: Nibble 0101 (arithmetic shift right): bits move one place right and bit 7 keeps its value. C takes the old bit 0, N is result bit 7, and V equals N xor C.
- R7: Nibble 0110 (logical shift right): a zero enters bit 7 and C takes the old bit 0. N is cleared, so V and S both equal the new C.
- R8: Nibble 0111 (rotate right through carry): the incoming C enters result bit 7 and the old bit 0 goes to C. N is result bit 7, and V equals N xor C.
- R9: For every recognised operation, Z is set exactly when the result is zero, and S equals N xor V.
- R10: For an instruction that is not recognised, `out_hit` is 0, `result` equals the operand, and `sreg_out` equals `sreg_in`.
- R11: Status bits 7:6 always pass through unchanged. H (bit 5) passes through for every operation except negate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs carry an instruction this cycle |
| instr | input | 16 | Instruction word |
| operand | input | 8 | Current value of the destination register |
| sreg_in | input | 8 | Current status byte |
| out_valid | output | 1 | Registered outputs hold a new result |
| out_hit | output | 1 | The instruction belonged to this group |
| result | output | 8 | Value to write back |
| dest | output | 5 | Destination register index |
| sreg_out | output | 8 | Updated status byte |

## Verification
The assertions assume that `in_valid`, `instr`, `operand` and `sreg_in` carry known values at every rising edge after reset. They also assume that the instruction is judged only at the edge where `in_valid` is high, because their consequents compare against the inputs of that edge through `$past`. To stay within these assumptions, the stimulus drives every input on the falling edge and never leaves one undriven. Most random words are built by placing a legal nibble and a random destination under the fixed prefix. The remaining words are fully random, which exercises the not-recognised path without breaking the assumptions.

// File: rtl/unary_alu.sv
module unary_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [15:0]  instr,
  input  logic [W-1:0] operand,
  input  logic [7:0]   sreg_in,
  output logic         out_valid,
  output logic         out_hit,
  output logic [W-1:0] result,
  output logic [4:0]   dest,
  output logic [7:0]   sreg_out
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_POS = ~MIN_NEG;

  logic         prefix_ok;
  logic         hit;
  logic [W-1:0] res;
  logic         c_n, v_n, n_n, h_n, z_n, s_n;
  logic [7:0]   flags;

  assign prefix_ok = (instr[15:9] == 7'b1001010);

  always_comb begin
    hit = prefix_ok;
    res = operand;
    c_n = sreg_in[0];
    h_n = sreg_in[5];
    n_n = 1'b0;
    v_n = 1'b0;
    case (instr[3:0])
      4'b0000: begin
        res = ~operand;
        c_n = 1'b1;
        n_n = res[MSB];
      end
      4'b0001: begin
        res = -operand;
        n_n = res[MSB];
        v_n = (res == MIN_NEG);
        c_n = (res != '0);
        h_n = res[3] & ~operand[3];
      end
      4'b0011: begin
        res = operand + 1'b1;
        n_n = res[MSB];
        v_n = (res == MIN_NEG);
      end
      4'b1010: begin
        res = operand - 1'b1;
        n_n = res[MSB];
        v_n = (res == MAX_POS);
      end
      4'b0101: begin
        res = {operand[MSB], operand[MSB:1]};
        c_n = operand[0];
        n_n = res[MSB];
        v_n = n_n ^ c_n;
      end
      4'b0110: begin
        res = {1'b0, operand[MSB:1]};
        c_n = operand[0];
        v_n = c_n;
      end
      4'b0111: begin
        res = {sreg_in[0], operand[MSB:1]};
        c_n = operand[0];
        n_n = res[MSB];
        v_n = n_n ^ c_n;
      end
      default: hit = 1'b0;
    endcase
  end

  assign z_n   = (res == '0);
  assign s_n   = n_n ^ v_n;
  assign flags = {sreg_in[7:6], h_n, s_n, v_n, n_n, z_n, c_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      result    <= '0;
      dest      <= '0;
      sreg_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit  <= hit;
        dest     <= instr[8:4];
        result   <= hit ? res : operand;
        sreg_out <= hit ? flags : sreg_in;
      end
    end
  end
endmodule

// File: rtl/unary_alu_chk.sv
module unary_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [15:0]  instr,
  input logic [W-1:0] operand,
  input logic [7:0]   sreg_in,
  input logic         out_valid,
  input logic         out_hit,
  input logic [W-1:0] result,
  input logic [4:0]   dest,
  input logic [7:0]   sreg_out
);
  logic pre, legal, is_inc, is_dec, is_lsr, is_neg;
  assign pre    = instr[15:9] == 7'b1001010;
  assign is_inc = pre && instr[3:0] == 4'b0011;
  assign is_dec = pre && instr[3:0] == 4'b1010;
  assign is_lsr = pre && instr[3:0] == 4'b0110;
  assign is_neg = pre && instr[3:0] == 4'b0001;
  assign legal  = pre && (instr[3:0] inside {4'b0000, 4'b0001, 4'b0011,
                          4'b0101, 4'b0110, 4'b0111, 4'b1010});

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  // R1
  dest_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> dest == $past(instr[8:4]));

  // R4
  inc_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_inc |=> sreg_out[0] == $past(sreg_in[0]));

  // R5
  dec_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_dec |=> sreg_out[0] == $past(sreg_in[0]));

  // R7
  lsr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_lsr |=> !sreg_out[2] && sreg_out[3] == sreg_out[0]
                            && sreg_out[4] == sreg_out[0] && !result[W-1]);

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> sreg_out[1] == (result == '0));

  // R9
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> sreg_out[4] == (sreg_out[2] ^ sreg_out[3]));

  // R10
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !legal |=> !out_hit && result == $past(operand)
                           && sreg_out == $past(sreg_in));

  // R11
  upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> sreg_out[7:6] == $past(sreg_in[7:6]));

  // R11
  half_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !is_neg |=> sreg_out[5] == $past(sreg_in[5]));
endmodule

bind unary_alu unary_alu_chk #(.W(W)) u_chk (.*);

// File: tb/unary_alu_bench.sv
module unary_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0]  operand = '0;
  logic [7:0]  sreg_in = '0;
  logic        out_valid, out_hit;
  logic [7:0]  result, sreg_out;
  logic [4:0]  dest;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  unary_alu u_unary_alu (.*);

  // model: returns {hit, result, status}
  function automatic logic [16:0] model(input logic [15:0] iw,
                                        input logic [7:0] d,
                                        input logic [7:0] s);
    logic [7:0] r;
    logic c, v, n, h, ok;
    ok = iw[15:9] == 7'b1001010;
    r = d; c = s[0]; h = s[5]; n = 0; v = 0;
    case (iw[3:0])
      4'h0: begin r = 8'hFF ^ d; c = 1; v = 0; end
      4'h1: begin r = 8'(256 - d); v = r == 8'h80; c = r != 0; h = r[3] & ~d[3]; end
      4'h3: begin r = 8'(d + 1); v = r == 8'h80; end
      4'hA: begin r = 8'(d - 1); v = r == 8'h7F; end
      4'h5: begin r = 8'($signed(d) >>> 1); c = d[0]; v = r[7] ^ d[0]; end
      4'h6: begin r = d >> 1; c = d[0]; v = d[0]; end
      4'h7: begin r = {s[0], d[7:1]}; c = d[0]; v = s[0] ^ d[0]; end
      default: ok = 0;
    endcase
    n = r[7];
    if (!ok) return {1'b0, d, s};
    return {1'b1, r, s[7:6], h, n ^ v, v, n, r == 0, c};
  endfunction

  function automatic string tag_of(input logic [15:0] iw);
    if (iw[15:9] != 7'b1001010) return "R10";
    case (iw[3:0])
      4'h0: return "R2";
      4'h1: return "R3";
      4'h3: return "R4";
      4'hA: return "R5";
      4'h5: return "R6";
      4'h6: return "R7";
      4'h7: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic run(input logic [15:0] iw, input logic [7:0] d, input logic [7:0] s);
    logic [16:0] e;
    e = model(iw, d, s);
    @(negedge clk);
    in_valid = 1; instr = iw; operand = d; sreg_in = s;
    @(negedge clk);
    in_valid = 0;
    checks++;
    if ({out_hit, result, sreg_out} !== e || dest !== iw[8:4] || out_valid !== 1'b1) begin
      fails++;
      $display("FAIL %s/R1/R9/R11 instr=%h got hit=%b res=%h sreg=%h dest=%h v=%b exp hit=%b res=%h sreg=%h dest=%h",
               tag_of(iw), iw, out_hit, result, sreg_out, dest, out_valid,
               e[16], e[15:8], e[7:0], iw[8:4]);
    end
  endtask

  function automatic logic [15:0] mk(input logic [3:0] nib, input logic [4:0] d);
    return {7'b1001010, d, nib};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({out_valid, out_hit, result, dest, sreg_out} !== '0) begin
      fails++;
      $display("FAIL R1 reset got %b expected 0", {out_valid, out_hit, result, dest, sreg_out});
    end
    rst_n = 1;
    run(mk(4'h0, 5'd16), 8'hFF, 8'h00);  // R2 complement to zero
    run(mk(4'h1, 5'd3),  8'h80, 8'h00);  // R3 negate 0x80
    run(mk(4'h1, 5'd4),  8'h00, 8'h21);  // R3 negate zero
    run(mk(4'h1, 5'd5),  8'h01, 8'h00);  // R3 H
    run(mk(4'h3, 5'd31), 8'h7F, 8'h01);  // R4 into 0x80, C kept
    run(mk(4'h3, 5'd0),  8'hFF, 8'h00);  // R4 wrap
    run(mk(4'hA, 5'd7),  8'h80, 8'h01);  // R5 into 0x7F
    run(mk(4'hA, 5'd8),  8'h00, 8'h00);  // R5 wrap
    run(mk(4'h5, 5'd9),  8'h81, 8'h00);  // R6 sign kept
    run(mk(4'h6, 5'd10), 8'h01, 8'hC0);  // R7 to zero, C
    run(mk(4'h7, 5'd11), 8'h02, 8'h01);  // R8 carry in
    run(mk(4'h7, 5'd12), 8'h01, 8'h00);  // R8 carry out
    run(mk(4'h2, 5'd13), 8'h5A, 8'hE7);  // R10 unused nibble
    run(16'h1234,        8'hA5, 8'h3C);  // R10 other prefix
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 out_valid got %b expected 0", out_valid);
    end
    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      logic [3:0] nibs [7] = '{4'h0, 4'h1, 4'h3, 4'h5, 4'h6, 4'h7, 4'hA};
      logic [15:0] iw;
      if ($urandom_range(0, 7) == 0) iw = 16'($urandom);
      else iw = mk(nibs[$urandom_range(0, 6)], 5'($urandom));
      run(iw, 8'($urandom), 8'($urandom));
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired got hang expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule